// File: doc/BRIEF.md
# Operand Effective Address Generator

This block resolves one operand of a 16-bit register-to-register CPU instruction. It receives the addressing-mode selector, the index and current contents of the named register, the instruction's extension word, the program counter and a byte/word flag. One clock later it presents one of two results. The first is an effective memory address, with a flag saying a memory read is due. The second is a ready operand value that needs no memory access.

Two modes need more than an address. Auto-increment mode also yields a register write-back that advances the pointer by the operand size. Modes that consume an extension word request that the program counter step past that word. A side selector marks the operand as source or destination. The destination side takes only the register, indexed, symbolic and absolute modes and flags any other mode as illegal.

Top module: `opaddr_unit`

## Requirements
- R1: Mode code 0 (register): the result is the register contents, marked as a value (`res_is_val`=1), with no memory read and no PC step. For a byte operand only bits 7:0 are kept and the upper bits read zero.
- R2: Mode code 1 (indexed): the result is the address extension word + register value, modulo 2^16, with a memory read and a PC step.
- R3: Mode code 2 (symbolic): the result is the address PC input + extension word, modulo 2^16, with a memory read and a PC step. The PC input is the address of the extension word.
- R4: Mode code 3 (absolute): the result is the extension word itself as an address, with a memory read and a PC step.
- R5: Mode code 4 (indirect): the result is the register value as an address, with a memory read and no PC step.
- R6: Mode code 5 (auto-increment): the result is the register value as an address, with a memory read. A write-back to the same register index carries the register value + 2 for a word or + 1 for a byte, modulo 2^16.
- R7: Mode code 6 (immediate): the result is the extension word, marked as a value, with a PC step and no memory read. A byte operand keeps only bits 7:0.
- R8: Mode code 7 on either side is illegal, and so are destination-side (`req_dst`=1) modes 4 to 7. An illegal operand raises `res_illegal` with a zero result and no read, write-back or PC step. Destination-side modes 0 to 3 behave as on the source side.
- R9: All results are registered. `res_valid` is high exactly in the cycle after a cycle with `req_valid` high. In every other cycle all result outputs are zero, and write-back index and value are zero whenever no write-back is signalled.
- R10: While `rst_n` is low all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operand request present this cycle |
| req_dst | input | 1 | 1 = destination operand, 0 = source |
| req_mode | input | 3 | Addressing-mode code 0..7 |
| req_byte | input | 1 | 1 = byte operand, 0 = word |
| req_idx | input | 4 | Index of the named register |
| req_reg | input | 16 | Current contents of that register |
| req_ext | input | 16 | Extension word of the instruction |
| req_pc | input | 16 | Address of the extension word |
| res_valid | output | 1 | Result present |
| res_data | output | 16 | Effective address or operand value |
| res_is_val | output | 1 | res_data is an operand value |
| res_mem_rd | output | 1 | Memory read at res_data is needed |
| res_pc_step | output | 1 | Advance PC by 2 past the extension word |
| res_illegal | output | 1 | Mode not allowed on this side |
| res_wb_en | output | 1 | Register write-back requested |
| res_wb_idx | output | 4 | Write-back register index |
| res_wb_val | output | 16 | Write-back value |

## Verification
In auto-increment mode two results come out in the same cycle. The memory-read address must carry the register's old value, and the write-back must carry the new one. The bench drives word and byte operands with pointer values near 0xFFFF, so the increment wraps while the address does not. It judges both fields against values computed from R6. It also sends back-to-back requests that alternate between auto-increment and other modes. This confirms that the write-back appears only in the cycle that belongs to its own request.

// File: rtl/opaddr_unit.sv
module opaddr_unit #(
  parameter int W  = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_dst,
  input  logic [2:0]    req_mode,
  input  logic          req_byte,
  input  logic [RW-1:0] req_idx,
  input  logic [W-1:0]  req_reg,
  input  logic [W-1:0]  req_ext,
  input  logic [W-1:0]  req_pc,
  output logic          res_valid,
  output logic [W-1:0]  res_data,
  output logic          res_is_val,
  output logic          res_mem_rd,
  output logic          res_pc_step,
  output logic          res_illegal,
  output logic          res_wb_en,
  output logic [RW-1:0] res_wb_idx,
  output logic [W-1:0]  res_wb_val
);
  localparam logic [2:0] M_REG = 3'd0, M_IDX = 3'd1, M_SYM = 3'd2, M_ABS = 3'd3,
                         M_IND = 3'd4, M_INC = 3'd5, M_IMM = 3'd6;
  localparam logic [W-1:0] BMASK = W'(8'hFF);
  localparam logic [W-1:0] STEP_B = W'(1);
  localparam logic [W-1:0] STEP_W = W'(2);

  logic [W-1:0]  n_data, n_wb_val;
  logic          n_is_val, n_rd, n_pc, n_ill, n_wb;
  logic [RW-1:0] n_wb_idx;
  logic          dst_bad;

  assign dst_bad = req_dst & req_mode[2];

  always_comb begin
    n_data = '0; n_is_val = 1'b0; n_rd = 1'b0; n_pc = 1'b0;
    n_ill = 1'b0; n_wb = 1'b0; n_wb_idx = '0; n_wb_val = '0;
    if (dst_bad) n_ill = 1'b1;
    else begin
      case (req_mode)
        M_REG: begin n_data = req_byte ? (req_reg & BMASK) : req_reg; n_is_val = 1'b1; end
        M_IDX: begin n_data = req_ext + req_reg; n_rd = 1'b1; n_pc = 1'b1; end
        M_SYM: begin n_data = req_pc + req_ext;  n_rd = 1'b1; n_pc = 1'b1; end
        M_ABS: begin n_data = req_ext;           n_rd = 1'b1; n_pc = 1'b1; end
        M_IND: begin n_data = req_reg;           n_rd = 1'b1; end
        M_INC: begin
          n_data   = req_reg;
          n_rd     = 1'b1;
          n_wb     = 1'b1;
          n_wb_idx = req_idx;
          n_wb_val = req_reg + (req_byte ? STEP_B : STEP_W);
        end
        M_IMM: begin n_data = req_byte ? (req_ext & BMASK) : req_ext; n_is_val = 1'b1; n_pc = 1'b1; end
        default: n_ill = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      res_valid <= 1'b0; res_data <= '0; res_is_val <= 1'b0; res_mem_rd <= 1'b0;
      res_pc_step <= 1'b0; res_illegal <= 1'b0; res_wb_en <= 1'b0;
      res_wb_idx <= '0; res_wb_val <= '0;
    end else begin
      res_valid <= 1'b1; res_data <= n_data; res_is_val <= n_is_val; res_mem_rd <= n_rd;
      res_pc_step <= n_pc; res_illegal <= n_ill; res_wb_en <= n_wb;
      res_wb_idx <= n_wb_idx; res_wb_val <= n_wb_val;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(req_valid));
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_data == '0 && !res_illegal && !res_wb_en && !res_mem_rd));
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (!res_wb_en && !res_mem_rd && !res_pc_step && res_data == '0));
  a_r1_value_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    res_is_val |-> !res_mem_rd);
  a_r6_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    res_wb_en |-> (res_mem_rd && (res_wb_val - res_data == STEP_B || res_wb_val - res_data == STEP_W)));
  a_r6_no_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    res_wb_en |-> !res_pc_step);
endmodule

// File: tb/opaddr_unit_bench.sv
module opaddr_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_dst = 1'b0, req_byte = 1'b0;
  logic [2:0] req_mode = '0;
  logic [3:0] req_idx = '0;
  logic [15:0] req_reg = '0, req_ext = '0, req_pc = '0;
  logic res_valid, res_is_val, res_mem_rd, res_pc_step, res_illegal, res_wb_en;
  logic [15:0] res_data, res_wb_val;
  logic [3:0] res_wb_idx;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  opaddr_unit u_opaddr_unit (.*);

  // order: valid,is_val,mem_rd,pc_step,illegal,wb_en,wb_idx,wb_val,data
  function automatic logic [41:0] pack_res();
    return {res_valid, res_is_val, res_mem_rd, res_pc_step, res_illegal, res_wb_en,
            res_wb_idx, res_wb_val, res_data};
  endfunction

  function automatic logic [41:0] mk(bit v, bit isv, bit rd, bit pc, bit ill, bit wb,
                                     logic [3:0] wi, logic [15:0] wv, logic [15:0] d);
    return {v, isv, rd, pc, ill, wb, wi, wv, d};
  endfunction

  task automatic chk(string tag, logic [41:0] exp);
    logic [41:0] act = pack_res();
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(bit dst, logic [2:0] m, bit by, logic [3:0] ix,
                       logic [15:0] rv, logic [15:0] ex, logic [15:0] pc);
    @(negedge clk);
    req_valid = 1; req_dst = dst; req_mode = m; req_byte = by;
    req_idx = ix; req_reg = rv; req_ext = ex; req_pc = pc;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset", '0);
  endtask

  task automatic t_register();
    issue(0, 3'd0, 0, 4'd3, 16'hBEEF, 16'h1111, 16'h2222);
    chk("R1 word", mk(1,1,0,0,0,0,0,0,16'hBEEF));
    issue(0, 3'd0, 1, 4'd3, 16'hBEEF, 16'h1111, 16'h2222);
    chk("R1 byte", mk(1,1,0,0,0,0,0,0,16'h00EF));
  endtask

  task automatic t_indexed();
    issue(0, 3'd1, 0, 4'd5, 16'h0200, 16'h0006, 16'h0);
    chk("R2 sum", mk(1,0,1,1,0,0,0,0,16'h0206));
    issue(0, 3'd1, 1, 4'd5, 16'hFFF0, 16'h0020, 16'h0);
    chk("R2 wrap", mk(1,0,1,1,0,0,0,0,16'h0010));
  endtask

  task automatic t_symbolic();
    issue(0, 3'd2, 0, 4'd0, 16'h9999, 16'h0100, 16'hC002);
    chk("R3 pc rel", mk(1,0,1,1,0,0,0,0,16'hC102));
    issue(0, 3'd2, 0, 4'd0, 16'h9999, 16'hFFFE, 16'hC002);
    chk("R3 negative offset", mk(1,0,1,1,0,0,0,0,16'hC000));
  endtask

  task automatic t_absolute();
    issue(0, 3'd3, 0, 4'd2, 16'h1234, 16'h0160, 16'h5000);
    chk("R4 abs", mk(1,0,1,1,0,0,0,0,16'h0160));
  endtask

  task automatic t_indirect();
    issue(0, 3'd4, 0, 4'd10, 16'h0A00, 16'h7777, 16'h5000);
    chk("R5 ind", mk(1,0,1,0,0,0,0,0,16'h0A00));
  endtask

  task automatic t_autoinc();
    issue(0, 3'd5, 0, 4'd10, 16'h0A00, 16'h0, 16'h0);
    chk("R6 word", mk(1,0,1,0,0,1,4'd10,16'h0A02,16'h0A00));
    issue(0, 3'd5, 1, 4'd7, 16'h0A00, 16'h0, 16'h0);
    chk("R6 byte", mk(1,0,1,0,0,1,4'd7,16'h0A01,16'h0A00));
    issue(0, 3'd5, 0, 4'd15, 16'hFFFF, 16'h0, 16'h0);
    chk("R6 word wrap", mk(1,0,1,0,0,1,4'd15,16'h0001,16'hFFFF));
    issue(0, 3'd5, 1, 4'd1, 16'hFFFF, 16'h0, 16'h0);
    chk("R6 byte wrap", mk(1,0,1,0,0,1,4'd1,16'h0000,16'hFFFF));
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1; req_dst = 0; req_mode = 3'd5; req_byte = 0; req_idx = 4'd4;
    req_reg = 16'h0300; req_ext = 16'h0; req_pc = 16'h0;
    @(negedge clk);
    chk("R6 first of pair", mk(1,0,1,0,0,1,4'd4,16'h0302,16'h0300));
    req_mode = 3'd4; req_reg = 16'h0302;
    @(negedge clk);
    req_valid = 0;
    chk("R6 R9 no stale writeback", mk(1,0,1,0,0,0,0,0,16'h0302));
    @(negedge clk);
    chk("R9 idle zero", '0);
  endtask

  task automatic t_immediate();
    issue(0, 3'd6, 0, 4'd0, 16'h1111, 16'hA55A, 16'h4000);
    chk("R7 word", mk(1,1,0,1,0,0,0,0,16'hA55A));
    issue(0, 3'd6, 1, 4'd0, 16'h1111, 16'hA55A, 16'h4000);
    chk("R7 byte", mk(1,1,0,1,0,0,0,0,16'h005A));
  endtask

  task automatic t_dest();
    issue(1, 3'd1, 0, 4'd6, 16'h0100, 16'h0004, 16'h0);
    chk("R8 dst indexed", mk(1,0,1,1,0,0,0,0,16'h0104));
    issue(1, 3'd0, 0, 4'd6, 16'h0100, 16'h0004, 16'h0);
    chk("R8 dst register", mk(1,1,0,0,0,0,0,0,16'h0100));
    for (int m = 4; m < 8; m++) begin
      issue(1, 3'(m), 0, 4'd6, 16'h0100, 16'h0004, 16'h8000);
      chk($sformatf("R8 dst mode %0d illegal", m), mk(1,0,0,0,1,0,0,0,16'h0));
    end
    issue(0, 3'd7, 0, 4'd6, 16'h0100, 16'h0004, 16'h8000);
    chk("R8 src mode 7 illegal", mk(1,0,0,0,1,0,0,0,16'h0));
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    req_valid = 1; req_mode = 3'd5; req_dst = 0; req_reg = 16'h1000;
    rst_n = 0;
    @(negedge clk);
    chk("R10 reset overrides request", '0);
    req_valid = 0; rst_n = 1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle after reset", '0);
    t_register();
    t_indexed();
    t_symbolic();
    t_absolute();
    t_indirect();
    t_autoinc();
    t_back_to_back();
    t_immediate();
    t_dest();
    t_reset_mid();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule